// File: doc/BRIEF.md
# Sector Buffer Transfer Engine

This block moves data out of an on-chip sector buffer to one of two kinds of consumer. A host can pull the data one 16-bit word at a time, or the engine can copy a block by DMA into one of three destination memories: a sound-sample memory, a program memory or a work memory. Before starting a transfer, software loads three counters. The address counter says where in the buffer the data starts. The byte counter says how many bytes to move. The destination register says where the DMA data goes. A trigger strobe then starts the transfer, but only when output is enabled and the 3-bit destination select holds a valid code.

The status outputs are active low where the programming model needs it. `busy_n` and `dready_n` are low while a transfer runs and while host data is available. `end_pend_n` is low while a transfer-end event waits to be acknowledged. The byte counter is treated as signed. A transfer ends when the counter reaches zero or goes negative. At that point the top four bits of the counter are set as a marker, the end-of-transfer flag rises, and an interrupt request is raised if it is enabled. DMA writes one word per clock. The destination byte address is scaled from the destination register in a way that depends on the target memory. Writes that would fall past the end of the target memory are suppressed.

The buffer holds 2^`BUF_AW` bytes, and every address into it is wrapped to that size. The full-size configuration uses `BUF_AW` = 14 (16 KB). A byte-wide write port fills the buffer.

Top module: `xfer_engine`

## Requirements
- R1: The buffer word is read at the address counter with bit 0 cleared and wrapped to the buffer size. The word is big-endian: the byte at the even address is bits 15:8 and the next byte is bits 7:0. `host_data` and `dma_data` both show this word.
- R2: In host mode, a `host_rd` pulse while `dready_n` is 0 adds 2 to the address counter and subtracts 2 from the byte counter. A `host_rd` pulse while `dready_n` is 1 changes nothing.
- R3: A host read ends the transfer when the decremented byte counter, read as a signed 16-bit value, is 0 or less. At the end the counter keeps its low 12 bits and gets bits 15:12 set to 4'hF. `busy_n` and `dready_n` return to 1, and `end_pend_n` goes to 0.
- R4: At the end of any transfer, `edt` goes to 1 and `dsr` to 0. `irq` equals `irq_en` while `end_pend_n` is 0. An `end_ack` pulse returns `end_pend_n` to 1.
- R5: Destination select codes are: 2 and 3 for host read, 4 for sample memory, 5 for program memory, 7 for work memory. A trigger with codes 0, 1 or 6 starts nothing and leaves `busy_n` at 1.
- R6: A trigger is acted on only while `out_en` is 1. A valid trigger drives `busy_n` to 0, clears bits 15:12 of the byte counter and clears `edt`. In host modes it also drives `dready_n` to 0 and sets `dsr` to 1.
- R7: The DMA start byte address depends on the target. For sample memory it is (dst << 2) AND 0xFFC. For program memory it is dst << 3. For work memory it is (dst << 3) AND 0x3FFF8. Successive words go to addresses 2 bytes apart, and exactly one of `pcm_we`, `prg_we`, `wrk_we` is high for each write.
- R8: A DMA moves W = (bytecount[11:0] + 1) >> 1 words, one per clock, starting with the word at the address counter. Afterwards the address counter has grown by 2W, and the byte counter is (count − 2W) with bits 15:12 set.
- R9: After a DMA, the destination register has grown by W >> 1 for sample memory and by W >> 2 for program or work memory.
- R10: DMA writes whose byte address is at or beyond the target size are suppressed. The target sizes are 4 KB for sample memory, 512 KB for program memory and 256 KB for work memory.
- R11: After reset `busy_n`, `dready_n` and `end_pend_n` are 1. `edt`, `dsr`, `irq`, all write strobes and all three counters are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| buf_we | input | 1 | Buffer byte write strobe |
| buf_waddr | input | BUF_AW | Buffer byte write address |
| buf_wdata | input | 8 | Buffer byte write data |
| dest_sel | input | 3 | Destination select code |
| out_en | input | 1 | Output enable; gates the trigger |
| irq_en | input | 1 | Transfer-end interrupt enable |
| dac_ld | input | 1 | Load the address counter (idle only) |
| dac_in | input | 16 | Address counter load value |
| dbc_ld | input | 1 | Load the byte counter (idle only) |
| dbc_in | input | 16 | Byte counter load value |
| dst_ld | input | 1 | Load the destination register (idle only) |
| dst_in | input | 16 | Destination register load value |
| trig | input | 1 | Transfer start strobe |
| host_rd | input | 1 | Host word consume strobe |
| end_ack | input | 1 | Acknowledge of the pending transfer end |
| host_data | output | 16 | Buffer word at the address counter |
| dma_data | output | 16 | Data of the current DMA write |
| dma_addr | output | PRG_AW+1 | Byte address of the current DMA write |
| pcm_we | output | 1 | Sample memory write strobe |
| prg_we | output | 1 | Program memory write strobe |
| wrk_we | output | 1 | Work memory write strobe |
| busy_n | output | 1 | Transfer in progress, active low |
| dready_n | output | 1 | Host data available, active low |
| end_pend_n | output | 1 | Transfer end pending, active low |
| edt | output | 1 | End of transfer flag |
| dsr | output | 1 | Host data set ready flag |
| irq | output | 1 | Transfer-end interrupt request |
| dac_out | output | 16 | Address counter value |
| dbc_out | output | 16 | Byte counter value |
| dst_out | output | 16 | Destination register value |

## Verification
Some rules hold on every cycle, and the assertions check these:
- At most one write strobe is high at a time.
- A sample-memory write never lands outside its 4 KB.
- Data-ready low implies busy low.
- Every end of a transfer sets the counter's top nibble and releases both status bits.
- Every accepted host read steps the address counter by 2.
- Rejected triggers leave the engine idle.

Other behaviour needs a known buffer content and known counter values, so only the directed scenarios can show it:
- The big-endian word order and the wrap of the buffer address.
- The exact word count for odd and even byte counts.
- The address scaling for each target.
- The destination register advance.
- The number of writes left after a clipped DMA.

// File: rtl/xfe_pkg.sv
package xfe_pkg;

    typedef enum logic [1:0] {
        MD_IDLE = 2'd0,
        MD_HOST = 2'd1,
        MD_DMA  = 2'd2
    } mode_e;

    typedef enum logic [1:0] {
        TG_PCM = 2'd0,
        TG_PRG = 2'd1,
        TG_WRK = 2'd2
    } tgt_e;

    localparam logic [2:0] SEL_HOST_A = 3'd2;
    localparam logic [2:0] SEL_HOST_B = 3'd3;
    localparam logic [2:0] SEL_PCM    = 3'd4;
    localparam logic [2:0] SEL_PRG    = 3'd5;
    localparam logic [2:0] SEL_WRK    = 3'd7;

endpackage

// File: rtl/xfe_sel_dec.sv
module xfe_sel_dec
    import xfe_pkg::*;
(
    input  logic [2:0] sel,
    output logic       valid,
    output logic       is_host,
    output tgt_e       tgt
);
    always_comb begin
        valid   = 1'b1;
        is_host = 1'b0;
        tgt     = TG_PCM;
        case (sel)
            SEL_HOST_A, SEL_HOST_B: is_host = 1'b1;
            SEL_PCM:                tgt     = TG_PCM;
            SEL_PRG:                tgt     = TG_PRG;
            SEL_WRK:                tgt     = TG_WRK;
            default:                valid   = 1'b0;
        endcase
    end
endmodule

// File: rtl/xfe_dst_map.sv
module xfe_dst_map
    import xfe_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int PCM_AW = 12,
    parameter int PRG_AW = 19,
    parameter int WRK_AW = 18,
    parameter int DP_W   = PRG_AW + 1
) (
    input  tgt_e              tgt,
    input  logic [CNT_W-1:0]  dst,
    output logic [DP_W-1:0]   base
);
    localparam int SH_W = CNT_W + 3;

    logic [SH_W-1:0] dst_x8;
    logic [DP_W-1:0] base_pcm;
    logic [DP_W-1:0] base_prg;
    logic [DP_W-1:0] base_wrk;

    assign dst_x8   = {dst, 3'b000};
    // sample memory: register counts 4-byte units, wrapped to its size
    assign base_pcm = DP_W'({dst[PCM_AW-3:0], 2'b00});
    // program and work memory: register counts 8-byte units
    assign base_prg = DP_W'(dst_x8[PRG_AW-1:0]);
    assign base_wrk = DP_W'(dst_x8[WRK_AW-1:0]);

    always_comb begin
        case (tgt)
            TG_PRG:  base = base_prg;
            TG_WRK:  base = base_wrk;
            default: base = base_pcm;
        endcase
    end
endmodule

// File: rtl/xfe_buffer.sv
module xfe_buffer #(
    parameter int BUF_AW = 12
) (
    input  logic              clk,
    input  logic              we,
    input  logic [BUF_AW-1:0] waddr,
    input  logic [7:0]        wdata,
    input  logic [BUF_AW-2:0] raddr,
    output logic [15:0]       rword
);
    localparam int WORDS = 1 << (BUF_AW - 1);

    logic [BUF_AW-2:0] widx;
    assign widx = waddr[BUF_AW-1:1];

    genvar g;
    generate
        for (g = 0; g < 2; g++) begin : g_lane
            // lane 1 holds the even byte (upper half), lane 0 the odd byte
            logic [7:0] mem [WORDS];
            always_ff @(posedge clk) begin
                if (we && (waddr[0] == (g == 0))) begin
                    mem[widx] <= wdata;
                end
            end
            assign rword[g*8 +: 8] = mem[raddr];
        end
    endgenerate
endmodule

// File: rtl/xfer_engine.sv
module xfer_engine
    import xfe_pkg::*;
#(
    parameter int BUF_AW = 12,
    parameter int PCM_AW = 12,
    parameter int PRG_AW = 19,
    parameter int WRK_AW = 18
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                buf_we,
    input  logic [BUF_AW-1:0]   buf_waddr,
    input  logic [7:0]          buf_wdata,
    input  logic [2:0]          dest_sel,
    input  logic                out_en,
    input  logic                irq_en,
    input  logic                dac_ld,
    input  logic [15:0]         dac_in,
    input  logic                dbc_ld,
    input  logic [15:0]         dbc_in,
    input  logic                dst_ld,
    input  logic [15:0]         dst_in,
    input  logic                trig,
    input  logic                host_rd,
    input  logic                end_ack,
    output logic [15:0]         host_data,
    output logic [15:0]         dma_data,
    output logic [PRG_AW:0]     dma_addr,
    output logic                pcm_we,
    output logic                prg_we,
    output logic                wrk_we,
    output logic                busy_n,
    output logic                dready_n,
    output logic                end_pend_n,
    output logic                edt,
    output logic                dsr,
    output logic                irq,
    output logic [15:0]         dac_out,
    output logic [15:0]         dbc_out,
    output logic [15:0]         dst_out
);
    localparam int CNT_W = 16;
    localparam int LEN_W = CNT_W - 4;
    localparam int DP_W  = PRG_AW + 1;

    localparam logic [DP_W-1:0]  LIM_PCM = DP_W'(1) << PCM_AW;
    localparam logic [DP_W-1:0]  LIM_PRG = DP_W'(1) << PRG_AW;
    localparam logic [DP_W-1:0]  LIM_WRK = DP_W'(1) << WRK_AW;
    localparam logic [CNT_W-1:0] TOP_NIB = {4'hF, {LEN_W{1'b0}}};
    localparam logic [CNT_W-1:0] STEP    = CNT_W'(2);

    typedef struct packed {
        mode_e             mode;
        tgt_e              tgt;
        logic [CNT_W-1:0]  dac;
        logic [CNT_W-1:0]  dbc;
        logic [CNT_W-1:0]  dst;
        logic [DP_W-1:0]   dptr;
        logic [LEN_W-1:0]  left;
        logic [CNT_W-1:0]  adv;
        logic              busy_n;
        logic              dready_n;
        logic              pend_n;
        logic              edt;
        logic              dsr;
    } st_t;

    st_t st_d, st_q;

    // ---------------- submodules ----------------
    logic        sel_valid;
    logic        sel_host;
    tgt_e        sel_tgt;
    logic [DP_W-1:0] start_base;
    logic [15:0] rd_word;

    xfe_sel_dec u_dec (
        .sel     (dest_sel),
        .valid   (sel_valid),
        .is_host (sel_host),
        .tgt     (sel_tgt)
    );

    xfe_dst_map #(
        .CNT_W  (CNT_W),
        .PCM_AW (PCM_AW),
        .PRG_AW (PRG_AW),
        .WRK_AW (WRK_AW),
        .DP_W   (DP_W)
    ) u_map (
        .tgt  (sel_tgt),
        .dst  (st_q.dst),
        .base (start_base)
    );

    xfe_buffer #(
        .BUF_AW (BUF_AW)
    ) u_buf (
        .clk   (clk),
        .we    (buf_we),
        .waddr (buf_waddr),
        .wdata (buf_wdata),
        .raddr (st_q.dac[BUF_AW-1:1]),
        .rword (rd_word)
    );

    // ---------------- next-state logic ----------------
    logic [LEN_W:0]    words_full;
    logic [LEN_W-1:0]  words;
    logic [CNT_W-1:0]  dbc_dec;
    logic [DP_W-1:0]   cur_lim;
    logic              dma_live;

    assign words_full = ({1'b0, st_q.dbc[LEN_W-1:0]} + 1'b1) >> 1;
    assign words      = words_full[LEN_W-1:0];
    assign dbc_dec    = st_q.dbc - STEP;

    always_comb begin
        case (st_q.tgt)
            TG_PRG:  cur_lim = LIM_PRG;
            TG_WRK:  cur_lim = LIM_WRK;
            default: cur_lim = LIM_PCM;
        endcase
    end

    assign dma_live = (st_q.mode == MD_DMA) && (st_q.left != '0);

    always_comb begin
        st_d = st_q;

        if (end_ack) begin
            st_d.pend_n = 1'b1;
        end

        case (st_q.mode)
            MD_IDLE: begin
                if (dac_ld) st_d.dac = dac_in;
                if (dbc_ld) st_d.dbc = dbc_in;
                if (dst_ld) st_d.dst = dst_in;
                if (trig && out_en && sel_valid) begin
                    st_d.busy_n = 1'b0;
                    st_d.dbc    = st_q.dbc & ~TOP_NIB;
                    st_d.edt    = 1'b0;
                    st_d.dsr    = 1'b0;
                    if (sel_host) begin
                        st_d.mode     = MD_HOST;
                        st_d.dready_n = 1'b0;
                        st_d.dsr      = 1'b1;
                    end else begin
                        st_d.mode = MD_DMA;
                        st_d.tgt  = sel_tgt;
                        st_d.dptr = start_base;
                        st_d.left = words;
                        st_d.adv  = (sel_tgt == TG_PCM)
                                    ? CNT_W'(words >> 1)
                                    : CNT_W'(words >> 2);
                    end
                end
            end

            MD_HOST: begin
                if (host_rd && !st_q.dready_n) begin
                    st_d.dac = st_q.dac + STEP;
                    if ($signed(dbc_dec) <= 0) begin
                        st_d.dbc      = dbc_dec | TOP_NIB;
                        st_d.mode     = MD_IDLE;
                        st_d.busy_n   = 1'b1;
                        st_d.dready_n = 1'b1;
                        st_d.pend_n   = 1'b0;
                        st_d.edt      = 1'b1;
                        st_d.dsr      = 1'b0;
                    end else begin
                        st_d.dbc = dbc_dec;
                    end
                end
            end

            MD_DMA: begin
                if (st_q.left != '0) begin
                    st_d.dac  = st_q.dac + STEP;
                    st_d.dbc  = dbc_dec;
                    st_d.dptr = st_q.dptr + DP_W'(2);
                    st_d.left = st_q.left - 1'b1;
                end else begin
                    st_d.dst      = st_q.dst + st_q.adv;
                    st_d.dbc      = st_q.dbc | TOP_NIB;
                    st_d.mode     = MD_IDLE;
                    st_d.busy_n   = 1'b1;
                    st_d.dready_n = 1'b1;
                    st_d.pend_n   = 1'b0;
                    st_d.edt      = 1'b1;
                    st_d.dsr      = 1'b0;
                end
            end

            default: st_d.mode = MD_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.mode     <= MD_IDLE;
            st_q.tgt      <= TG_PCM;
            st_q.dac      <= '0;
            st_q.dbc      <= '0;
            st_q.dst      <= '0;
            st_q.dptr     <= '0;
            st_q.left     <= '0;
            st_q.adv      <= '0;
            st_q.busy_n   <= 1'b1;
            st_q.dready_n <= 1'b1;
            st_q.pend_n   <= 1'b1;
            st_q.edt      <= 1'b0;
            st_q.dsr      <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    // ---------------- outputs ----------------
    logic wr_ok;
    assign wr_ok = dma_live && (st_q.dptr < cur_lim);

    assign host_data  = rd_word;
    assign dma_data   = rd_word;
    assign dma_addr   = st_q.dptr;
    assign pcm_we     = wr_ok && (st_q.tgt == TG_PCM);
    assign prg_we     = wr_ok && (st_q.tgt == TG_PRG);
    assign wrk_we     = wr_ok && (st_q.tgt == TG_WRK);
    assign busy_n     = st_q.busy_n;
    assign dready_n   = st_q.dready_n;
    assign end_pend_n = st_q.pend_n;
    assign edt        = st_q.edt;
    assign dsr        = st_q.dsr;
    assign irq        = irq_en && !st_q.pend_n;
    assign dac_out    = st_q.dac;
    assign dbc_out    = st_q.dbc;
    assign dst_out    = st_q.dst;

endmodule

// File: rtl/xfer_engine_chk.sv
module xfer_engine_chk #(
    parameter int PCM_AW = 12,
    parameter int PRG_AW = 19
) (
    input logic              clk,
    input logic              rst_n,
    input logic [2:0]        dest_sel,
    input logic              out_en,
    input logic              trig,
    input logic              host_rd,
    input logic [PRG_AW:0]   dma_addr,
    input logic              pcm_we,
    input logic              prg_we,
    input logic              wrk_we,
    input logic              busy_n,
    input logic              dready_n,
    input logic              end_pend_n,
    input logic              edt,
    input logic              dsr,
    input logic [15:0]       dac_out,
    input logic [15:0]       dbc_out
);
    localparam logic [PRG_AW:0] PCM_SIZE = (PRG_AW+1)'(1) << PCM_AW;

    logic sel_bad;
    assign sel_bad = (dest_sel == 3'd0) || (dest_sel == 3'd1) || (dest_sel == 3'd6);

    // R7: one target at a time
    p_one_port_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({pcm_we, prg_we, wrk_we}));

    // R10: sample-memory writes stay inside the memory
    p_pcm_in_range_r10: assert property (@(posedge clk) disable iff (!rst_n)
        pcm_we |-> (dma_addr < PCM_SIZE));

    // R6: host data ready only inside a running transfer
    p_ready_in_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !dready_n |-> !busy_n);

    // R3: every end marks the counter and releases the status bits
    p_end_marks_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_n) |-> (dbc_out[15:12] == 4'hF) && dready_n);

    // R4: pending end comes with the flags of a finished transfer
    p_end_flags_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(end_pend_n) |-> busy_n && edt && !dsr);

    // R2: accepted host read steps the address counter
    p_host_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (host_rd && !dready_n) |=> (dac_out == $past(dac_out) + 16'd2));

    // R6: trigger without output enable stays idle
    p_trig_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_n && trig && !out_en) |=> busy_n);

    // R5: invalid destination starts nothing
    p_bad_sel_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_n && trig && sel_bad) |=> busy_n);

endmodule

bind xfer_engine xfer_engine_chk #(
    .PCM_AW (PCM_AW),
    .PRG_AW (PRG_AW)
) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .dest_sel   (dest_sel),
    .out_en     (out_en),
    .trig       (trig),
    .host_rd    (host_rd),
    .dma_addr   (dma_addr),
    .pcm_we     (pcm_we),
    .prg_we     (prg_we),
    .wrk_we     (wrk_we),
    .busy_n     (busy_n),
    .dready_n   (dready_n),
    .end_pend_n (end_pend_n),
    .edt        (edt),
    .dsr        (dsr),
    .dac_out    (dac_out),
    .dbc_out    (dbc_out)
);

// File: tb/xfer_engine_tb_top.sv
module xfer_engine_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int BUF_AW = 12;
    localparam int PRG_AW = 19;
    localparam int NBYTES = 1 << BUF_AW;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic buf_we = 1'b0;
    logic [BUF_AW-1:0] buf_waddr = '0;
    logic [7:0] buf_wdata = '0;
    logic [2:0] dest_sel = '0;
    logic out_en = 1'b0, irq_en = 1'b0;
    logic dac_ld = 1'b0, dbc_ld = 1'b0, dst_ld = 1'b0;
    logic [15:0] dac_in = '0, dbc_in = '0, dst_in = '0;
    logic trig = 1'b0, host_rd = 1'b0, end_ack = 1'b0;
    logic [15:0] host_data, dma_data;
    logic [PRG_AW:0] dma_addr;
    logic pcm_we, prg_we, wrk_we;
    logic busy_n, dready_n, end_pend_n, edt, dsr, irq;
    logic [15:0] dac_out, dbc_out, dst_out;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    xfer_engine #(.BUF_AW(BUF_AW)) dut_i (
        .clk(clk), .rst_n(rst_n), .buf_we(buf_we), .buf_waddr(buf_waddr),
        .buf_wdata(buf_wdata), .dest_sel(dest_sel), .out_en(out_en),
        .irq_en(irq_en), .dac_ld(dac_ld), .dac_in(dac_in), .dbc_ld(dbc_ld),
        .dbc_in(dbc_in), .dst_ld(dst_ld), .dst_in(dst_in), .trig(trig),
        .host_rd(host_rd), .end_ack(end_ack), .host_data(host_data),
        .dma_data(dma_data), .dma_addr(dma_addr), .pcm_we(pcm_we),
        .prg_we(prg_we), .wrk_we(wrk_we), .busy_n(busy_n),
        .dready_n(dready_n), .end_pend_n(end_pend_n), .edt(edt), .dsr(dsr),
        .irq(irq), .dac_out(dac_out), .dbc_out(dbc_out), .dst_out(dst_out)
    );

    function automatic logic [7:0] pat(input int a);
        return 8'((a * 37) ^ (a >> 8) ^ 8'h5A);
    endfunction

    function automatic logic [15:0] exp_word(input logic [15:0] dac);
        int a;
        a = int'(dac) & (NBYTES - 2);
        return {pat(a), pat(a + 1)};
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic fill_buffer();
        for (int a = 0; a < NBYTES; a++) begin
            @(negedge clk);
            buf_we = 1'b1; buf_waddr = BUF_AW'(a); buf_wdata = pat(a);
        end
        @(negedge clk);
        buf_we = 1'b0;
    endtask

    task automatic load(input logic [15:0] dac, input logic [15:0] dbc, input logic [15:0] dst);
        @(negedge clk);
        dac_ld = 1'b1; dac_in = dac; dbc_ld = 1'b1; dbc_in = dbc; dst_ld = 1'b1; dst_in = dst;
        @(negedge clk);
        dac_ld = 1'b0; dbc_ld = 1'b0; dst_ld = 1'b0;
    endtask

    task automatic pulse_trig(input logic [2:0] sel, input logic oe);
        @(negedge clk);
        dest_sel = sel; out_en = oe; trig = 1'b1;
        @(negedge clk);
        trig = 1'b0;
    endtask

    task automatic pulse_rd();
        @(negedge clk);
        host_rd = 1'b1;
        @(negedge clk);
        host_rd = 1'b0;
    endtask

    task automatic ack();
        @(negedge clk);
        end_ack = 1'b1;
        @(negedge clk);
        end_ack = 1'b0;
    endtask

    task automatic t_reset();
        chk("R11 busy_n", busy_n, 1); chk("R11 dready_n", dready_n, 1);
        chk("R11 end_pend_n", end_pend_n, 1); chk("R11 edt", edt, 0);
        chk("R11 dsr", dsr, 0); chk("R11 irq", irq, 0);
        chk("R11 strobes", {pcm_we, prg_we, wrk_we}, 0);
        chk("R11 counters", {dac_out, dbc_out, dst_out}, 0);
    endtask

    // host read with buffer wrap, dbc odd, irq enabled
    task automatic t_host_wrap();
        logic [15:0] d;
        irq_en = 1'b1;
        load(16'h0FFC, 16'h3005, 16'h0);
        pulse_trig(3'd2, 1'b1);
        chk("R6 busy_n low", busy_n, 0); chk("R6 dready_n low", dready_n, 0);
        chk("R6 dsr set", dsr, 1); chk("R6 nibble cleared", dbc_out, 16'h0005);
        d = 16'h0FFC;
        for (int i = 0; i < 3; i++) begin
            chk("R1 host word", host_data, exp_word(d));
            pulse_rd();
            d = d + 16'd2;
            chk("R2 dac step", dac_out, d);
        end
        chk("R1 wrap dac", dac_out, 16'h1002);
        chk("R3 dbc marked", dbc_out, 16'hFFFF);
        chk("R3 busy_n high", busy_n, 1); chk("R3 dready_n high", dready_n, 1);
        chk("R3 end pending", end_pend_n, 0);
        chk("R4 edt", edt, 1); chk("R4 dsr clear", dsr, 0); chk("R4 irq", irq, 1);
        ack();
        chk("R4 ack clears", {end_pend_n, irq}, 2'b10);
    endtask

    // reads while idle, gated and invalid triggers
    task automatic t_ignored();
        logic [15:0] d0;
        d0 = dac_out;
        pulse_rd();
        chk("R2 idle read ignored", dac_out, d0);
        pulse_trig(3'd2, 1'b0);
        chk("R6 gated trigger", {busy_n, dready_n}, 2'b11);
        pulse_trig(3'd6, 1'b1);
        chk("R5 code 6 invalid", busy_n, 1);
        pulse_trig(3'd1, 1'b1);
        chk("R5 code 1 invalid", busy_n, 1);
        pulse_rd();
        chk("R2 read after bad trigger ignored", dac_out, d0);
    endtask

    // host read with even count, irq disabled
    task automatic t_host_even();
        irq_en = 1'b0;
        load(16'h0200, 16'h0004, 16'h0);
        pulse_trig(3'd3, 1'b1);
        chk("R5 code 3 host", dready_n, 0);
        pulse_rd();
        chk("R2 dbc step", dbc_out, 16'h0002);
        pulse_rd();
        chk("R3 dbc zero marked", dbc_out, 16'hF000);
        chk("R4 pend without irq", {end_pend_n, irq}, 2'b00);
        ack();
    endtask

    task automatic t_dma(input string tag, input logic [2:0] sel, input logic [15:0] dac,
                         input logic [15:0] dbc, input logic [15:0] dst,
                         input logic [PRG_AW:0] base, input int nwr,
                         input logic [15:0] dst_exp, input logic [15:0] dbc_exp);
        int n;
        int guard;
        int words;
        logic w_ok;
        words = ((int'(dbc) & 12'hFFF) + 1) >> 1;
        load(dac, dbc, dst);
        pulse_trig(sel, 1'b1);
        n = 0; guard = 0;
        while (!busy_n && guard < 5000) begin
            if (pcm_we | prg_we | wrk_we) begin
                w_ok = (sel == 3'd4) ? pcm_we : (sel == 3'd5) ? prg_we : wrk_we;
                chk({tag, " R7 port"}, w_ok, 1);
                chk({tag, " R7 addr"}, dma_addr, base + (PRG_AW+1)'(2 * n));
                chk({tag, " R8 data"}, dma_data, exp_word(dac + 16'(2 * n)));
                n++;
            end
            guard++;
            @(negedge clk);
        end
        chk({tag, " R10 write count"}, n, nwr);
        chk({tag, " R8 dac advance"}, dac_out, dac + 16'(2 * words));
        chk({tag, " R8 dbc end"}, dbc_out, dbc_exp);
        chk({tag, " R9 dst advance"}, dst_out, dst_exp);
        chk({tag, " R4 end flags"}, {edt, dsr, end_pend_n}, 3'b100);
        ack();
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        fill_buffer();
        t_host_wrap();
        t_ignored();
        t_host_even();
        // program memory: base dst<<3, 4 words, dst += 1
        t_dma("prg", 3'd5, 16'h0100, 16'h0007, 16'h0010, 20'h00080, 4, 16'h0011, 16'hFFFF);
        // work memory: base masked to 256 KB, 8 words, dst += 2
        t_dma("wrk", 3'd7, 16'h0FF8, 16'h0010, 16'h8002, 20'h00010, 8, 16'h8004, 16'hF000);
        // sample memory: base (dst<<2)&0xFFC, 3 words, dst += 1
        t_dma("pcm", 3'd4, 16'h0031, 16'h0006, 16'h0005, 20'h00014, 3, 16'h0006, 16'hF000);
        // sample memory clipped at 4 KB: 16 words, only 8 written, dst += 8
        t_dma("pcmclip", 3'd4, 16'h0400, 16'h001F, 16'h13FC, 20'h00FF0, 8, 16'h1404, 16'hFFFF);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule